// File: doc/BRIEF.md
# Four-Cycle Partial-Product Multiplier Sequencer

This block steers a narrow multiplier that builds a wide product from four slice products, one per clock. It owns a small wrapping cycle counter and a Mealy state machine. A one-cycle `start` pulse zeroes the counter and arms the sequence. On each of the next four cycles the machine reads the counter value and produces four things: the operand-slice select, the shift code that weights the slice product, an active-low accumulate enable, and, on the last slice, `done`. The accumulator clear is active low and synchronous. It is driven in the same cycle as `start`, so the accumulator is empty when the first slice product arrives.

The machine checks that the counter value matches the state it is in. Any mismatch sends it to a trap state, and so does a new `start` while a sequence is running. The trap state keeps the accumulator frozen until the next `start`, which clears the accumulator and begins a fresh sequence. Because all controls are decoded from the present state, `start` and the count, they are valid in the same cycle as those inputs. The state register and the counter change at the following edge.

Top module: `mpy_seq_ctrl`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, the state becomes IDLE (000) and the count becomes 0. While `rst_n` is low, the outputs are inactive whatever `start` is: enable_n=1, clear_n=1, done=0, select=0, shift=0.
- R2: `state_o` carries the present state in this encoding: IDLE=000, LSB=001, MID=010, MSB=011, ERR=100.
- R3: `cyc_cnt_o` advances by one modulo 4 at every rising edge outside reset. It becomes 0 at an edge where `start` is 1.
- R4: In IDLE with start=0, the state stays IDLE and the outputs are inactive. In IDLE with start=1, the outputs are clear_n=0 and enable_n=1, and the next state is LSB.
- R5: In LSB with start=0 and count 0, the outputs are select=0, shift=0, enable_n=0, clear_n=1 and done=0, and the next state is MID.
- R6: In MID with start=0, count 1 gives select=1 and keeps the state at MID, and count 2 gives select=2 and moves to MSB. Both give shift=1 and enable_n=0.
- R7: In MSB with start=0 and count 3, the outputs are select=3, shift=2, enable_n=0 and done=1, and the next state is IDLE. `done` is never high in any other case.
- R8: In LSB, MID or MSB, start=1 or a count that does not fit the state moves the machine to ERR. In that cycle the outputs are enable_n=1, clear_n=1, done=0, select=0 and shift=0.
- R9: ERR with start=0 stays in ERR with the outputs inactive. ERR with start=1 drives clear_n=0 and enable_n=1 and moves to LSB, after which the normal sequence runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request to begin a product |
| in_sel_o | output | 2 | Operand slice select |
| shift_o | output | 2 | Shifter code: 0 none, 1 one slice, 2 two slices |
| acc_en_n_o | output | 1 | Accumulator enable, active low |
| acc_clr_n_o | output | 1 | Accumulator synchronous clear, active low |
| done_o | output | 1 | High in the cycle the last slice is accumulated |
| state_o | output | 3 | Encoded present state |
| cyc_cnt_o | output | 2 | Cycle counter value |

## Verification
The control outputs are Mealy outputs and are due in the same cycle as the state, `start` and count that produce them. The state and the counter are due one edge later. The bench drives `start` just after a rising edge and compares every output at the following falling edge against a reference model that it advances only after the next rising edge. Each cycle therefore checks both the combinational decode and the registered outcome of the previous cycle. A sweep puts a second `start` at every offset from zero to several cycles after the first one. This covers back-to-back starts, a restart from each sequence state, a restart from ERR, and a clean return to IDLE.

// File: rtl/mpy_seq_pkg.sv
// Package: shared widths, state encoding and shift codes for the sequencer.
// Assumes a four-slice product, so the counter is two bits wide.
package mpy_seq_pkg;
    localparam int CNT_W = 2;
    localparam int SEL_W = CNT_W;
    localparam int SHF_W = 2;
    localparam int ST_W  = 3;

    typedef enum logic [ST_W-1:0] {
        ST_IDLE = 3'b000,
        ST_LSB  = 3'b001,
        ST_MID  = 3'b010,
        ST_MSB  = 3'b011,
        ST_ERR  = 3'b100
    } seq_st_e;

    localparam logic [SHF_W-1:0] SHF_NONE = 2'd0;
    localparam logic [SHF_W-1:0] SHF_ONE  = 2'd1;
    localparam logic [SHF_W-1:0] SHF_TWO  = 2'd2;

    typedef struct packed {
        seq_st_e          nxt;
        logic [SEL_W-1:0] sel;
        logic [SHF_W-1:0] shf;
        logic             en_n;
        logic             clr_n;
        logic             done;
    } seq_ctl_t;
endpackage

// File: rtl/mpy_cyc_ctr.sv
// Module: wrapping cycle counter that tracks the slice being processed.
// Assumes: start zeroes it synchronously; otherwise it counts every edge.
module mpy_cyc_ctr #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    output logic [W-1:0] cnt
);
    // Purpose: count every edge, zeroed by reset or start.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (start) cnt <= '0;
        else            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/mpy_seq_decode.sv
// Module: Mealy decode of present state, start and count into the next
// state and all datapath controls.
// Assumes: the count is zeroed at the edge where start is seen.
module mpy_seq_decode
    import mpy_seq_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  seq_st_e      st,
    input  logic         start,
    input  logic [W-1:0] cnt,
    output seq_ctl_t     ctl
);
    localparam logic [W-1:0] CNT_FIRST = '0;
    localparam logic [W-1:0] CNT_LAST  = '1;
    localparam logic [W-1:0] CNT_PREV  = CNT_LAST - 1'b1;

    // Purpose: pick the next state and the per-cycle controls.
    always_comb begin
        ctl       = '0;
        ctl.nxt   = st;
        ctl.en_n  = 1'b1;
        ctl.clr_n = 1'b1;
        case (st)
            ST_IDLE: begin
                if (start) begin
                    ctl.nxt   = ST_LSB;
                    ctl.clr_n = 1'b0;
                end
            end
            ST_LSB: begin
                if (!start && cnt == CNT_FIRST) begin
                    ctl.nxt  = ST_MID;
                    ctl.en_n = 1'b0;
                    ctl.sel  = SEL_W'(cnt);
                    ctl.shf  = SHF_NONE;
                end else begin
                    ctl.nxt = ST_ERR;
                end
            end
            ST_MID: begin
                if (!start && cnt > CNT_FIRST && cnt < CNT_LAST) begin
                    ctl.nxt  = (cnt == CNT_PREV) ? ST_MSB : ST_MID;
                    ctl.en_n = 1'b0;
                    ctl.sel  = SEL_W'(cnt);
                    ctl.shf  = SHF_ONE;
                end else begin
                    ctl.nxt = ST_ERR;
                end
            end
            ST_MSB: begin
                if (!start && cnt == CNT_LAST) begin
                    ctl.nxt  = ST_IDLE;
                    ctl.en_n = 1'b0;
                    ctl.sel  = SEL_W'(cnt);
                    ctl.shf  = SHF_TWO;
                    ctl.done = 1'b1;
                end else begin
                    ctl.nxt = ST_ERR;
                end
            end
            ST_ERR: begin
                if (start) begin
                    ctl.nxt   = ST_LSB;
                    ctl.clr_n = 1'b0;
                end
            end
            default: ctl.nxt = ST_ERR;
        endcase
    end
endmodule

// File: rtl/mpy_seq_state_reg.sv
// Module: present-state register with synchronous active-low reset.
// Assumes: the next state comes from the decode of the same cycle.
module mpy_seq_state_reg
    import mpy_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  seq_st_e nxt,
    output seq_st_e st
);
    // Purpose: hold the present state; reset returns to IDLE.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end
endmodule

// File: rtl/mpy_seq_ctrl.sv
// Module: top of the sequencer. Joins the counter, the state register and
// the decode, and holds the outputs inactive while reset is low.
// Assumes: start is a single-cycle pulse from the requester.
module mpy_seq_ctrl
    import mpy_seq_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int SW = SEL_W,
    parameter int HW = SHF_W,
    parameter int TW = ST_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic [SW-1:0] in_sel_o,
    output logic [HW-1:0] shift_o,
    output logic          acc_en_n_o,
    output logic          acc_clr_n_o,
    output logic          done_o,
    output logic [TW-1:0] state_o,
    output logic [CW-1:0] cyc_cnt_o
);
    logic [CW-1:0] cnt;
    seq_st_e       st;
    seq_ctl_t      ctl;

    mpy_cyc_ctr #(.W(CW)) u_ctr (
        .clk(clk), .rst_n(rst_n), .start(start), .cnt(cnt)
    );

    mpy_seq_decode #(.W(CW)) u_dec (
        .st(st), .start(start), .cnt(cnt), .ctl(ctl)
    );

    mpy_seq_state_reg u_st (
        .clk(clk), .rst_n(rst_n), .nxt(ctl.nxt), .st(st)
    );

    // Purpose: hold every control inactive while reset is low.
    always_comb begin
        in_sel_o    = rst_n ? SW'(ctl.sel) : '0;
        shift_o     = rst_n ? HW'(ctl.shf) : '0;
        acc_en_n_o  = rst_n ? ctl.en_n : 1'b1;
        acc_clr_n_o = rst_n ? ctl.clr_n : 1'b1;
        done_o      = rst_n & ctl.done;
    end

    assign state_o   = TW'(st);
    assign cyc_cnt_o = cnt;
endmodule

// File: rtl/mpy_seq_ctrl_chk.sv
// Module: temporal checks on the sequencer ports, bound to the top.
module mpy_seq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [1:0] in_sel_o,
    input logic [1:0] shift_o,
    input logic       acc_en_n_o,
    input logic       acc_clr_n_o,
    input logic       done_o,
    input logic [2:0] state_o,
    input logic [1:0] cyc_cnt_o
);
    a_r3_cnt_zero: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> cyc_cnt_o == 2'd0);
    a_r3_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> cyc_cnt_o == 2'($past(cyc_cnt_o) + 2'd1));
    a_r4_clr_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_clr_n_o |-> start);
    a_r5_lsb_to_mid: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'b001 && !start) |=> state_o == 3'b010);
    a_r7_done_in_msb: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (state_o == 3'b011 && cyc_cnt_o == 2'd3));
    a_r7_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> state_o == 3'b000);
    a_r8_restart_traps: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state_o inside {3'b001, 3'b010, 3'b011}) |=> state_o == 3'b100);
    a_r9_err_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'b100 && start) |=> state_o == 3'b001);
    a_r8_en_only_in_seq: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en_n_o |-> state_o inside {3'b001, 3'b010, 3'b011});
endmodule

bind mpy_seq_ctrl mpy_seq_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .in_sel_o(in_sel_o),
    .shift_o(shift_o), .acc_en_n_o(acc_en_n_o), .acc_clr_n_o(acc_clr_n_o),
    .done_o(done_o), .state_o(state_o), .cyc_cnt_o(cyc_cnt_o)
);

// File: tb/sim_mpy_seq_ctrl.sv
module sim_mpy_seq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] in_sel_o, shift_o, cyc_cnt_o;
    logic       acc_en_n_o, acc_clr_n_o, done_o;
    logic [2:0] state_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [2:0] m_st = 3'd0;
    logic [1:0] m_cnt = 2'd0;

    always #4 clk = ~clk;

    mpy_seq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .in_sel_o(in_sel_o),
        .shift_o(shift_o), .acc_en_n_o(acc_en_n_o), .acc_clr_n_o(acc_clr_n_o),
        .done_o(done_o), .state_o(state_o), .cyc_cnt_o(cyc_cnt_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one cycle: drive, check Mealy outputs at falling edge, advance model
    task automatic cyc(input logic s);
        logic [2:0] nx;
        logic [1:0] e_sel, e_shf;
        logic       e_en, e_clr, e_dn;
        string      tag;
        start = s;
        nx = m_st; e_sel = 0; e_shf = 0; e_en = 1; e_clr = 1; e_dn = 0;
        case (m_st)
            3'd0: begin tag = "R4"; if (s) begin nx = 3'd1; e_clr = 0; end end
            3'd1: begin tag = "R5";
                if (!s && m_cnt == 0) begin nx = 3'd2; e_en = 0; end
                else begin nx = 3'd4; tag = "R8"; end end
            3'd2: begin tag = "R6";
                if (!s && (m_cnt == 1 || m_cnt == 2)) begin
                    nx = (m_cnt == 2) ? 3'd3 : 3'd2; e_en = 0; e_sel = m_cnt; e_shf = 1;
                end else begin nx = 3'd4; tag = "R8"; end end
            3'd3: begin tag = "R7";
                if (!s && m_cnt == 3) begin nx = 3'd0; e_en = 0; e_sel = 3; e_shf = 2; e_dn = 1; end
                else begin nx = 3'd4; tag = "R8"; end end
            default: begin tag = "R9"; if (s) begin nx = 3'd1; e_clr = 0; end end
        endcase
        @(negedge clk);
        chk("R2 state", state_o, m_st);
        chk("R3 count", cyc_cnt_o, m_cnt);
        chk({tag, " sel"}, in_sel_o, e_sel);
        chk({tag, " shift"}, shift_o, e_shf);
        chk({tag, " en_n"}, acc_en_n_o, e_en);
        chk({tag, " clr_n"}, acc_clr_n_o, e_clr);
        chk({tag, " done"}, done_o, e_dn);
        @(posedge clk);
        m_st = nx;
        m_cnt = s ? 2'd0 : 2'(m_cnt + 1);
        #1;
    endtask

    task automatic chk_reset();
        @(negedge clk);
        chk("R1 state", state_o, 0);
        chk("R1 count", cyc_cnt_o, 0);
        chk("R1 en_n", acc_en_n_o, 1);
        chk("R1 clr_n", acc_clr_n_o, 1);
        chk("R1 done", done_o, 0);
        chk("R1 sel", in_sel_o, 0);
        chk("R1 shift", shift_o, 0);
    endtask

    initial begin
        #800000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 start = 1'b1;
        chk_reset();
        @(posedge clk); #1;
        rst_n = 1'b1; start = 1'b0;
        m_st = 0; m_cnt = 0;
        repeat (5) cyc(0);
        // plain sequences, back to back from IDLE
        cyc(1); repeat (4) cyc(0);
        cyc(1); repeat (4) cyc(0);
        repeat (3) cyc(0);
        // second start at every offset, then recovery from ERR
        for (int gap = 0; gap <= 6; gap++) begin
            cyc(1);
            for (int k = 0; k < gap; k++) cyc(0);
            cyc(1);
            repeat (6) cyc(0);
            if (m_st == 3'd4) begin
                cyc(1); repeat (5) cyc(0);
            end
        end
        // double start while in ERR
        cyc(1); cyc(1); repeat (3) cyc(0); cyc(1); cyc(1); repeat (6) cyc(0);
        // reset in mid-sequence
        cyc(1); cyc(0); cyc(0);
        rst_n = 1'b0;
        @(posedge clk); #1;
        chk_reset();
        @(posedge clk); #1;
        rst_n = 1'b1; m_st = 0; m_cnt = 0;
        cyc(1); repeat (6) cyc(0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule